// File: doc/BRIEF.md
# Packed DSCP-to-TID Map Table

This block turns a 6-bit DSCP code point into a 3-bit traffic identifier (TID) for a transmit classifier. It keeps 32 separate maps, each with 64 entries. A map ID picks one of them. The datapath sends a map ID and a DSCP value on the lookup port. One clock later it gets back the TID, plus an error flag if the map ID was out of range.

Software programs the maps through a 32-bit word-addressed register port. The 3-bit entries sit back to back in a continuous bit stream that spans six 32-bit words per map. Because of this packing, some entries cross the boundary between two words. A common control register holds a program-enable bit. Map words accept writes only while that bit is set. Software sets the bit, writes the words, and clears it again. Each map word can be read back at any time.

Top module: `dscp_tid_map`

## Requirements
- R1: After a synchronous reset, every map word reads 0, the program-enable bit reads 0, and every in-range lookup returns TID 0.
- R2: While program-enable is 1, a write to a map word address (0 to 191) stores the write data ANDed with the read mask, which is all ones by default. A read of the same address returns it on the next cycle.
- R3: While program-enable is 0, writes to map word addresses are ignored. Later reads and lookups still show the earlier contents.
- R4: The control register is at word address 192, with program-enable in bit 0. It always accepts writes. A read of it returns program-enable in bit 0 and zeros in bits 31:1.
- R5: When a lookup is presented with lk_valid high, res_valid, res_tid and res_err show its result one clock later. When res_valid is low, res_tid and res_err are 0.
- R6: Map n occupies word addresses 6n to 6n+5. Its bit stream starts at bit 0 of word 6n. DSCP entry d is stream bits 3d (the TID's LSB) to 3d+2.
- R7: An entry that crosses a word boundary (d = 10, 21, 42, 53) takes its low bits from the top of one word and the rest from the bottom of the next word.
- R8: A lookup with a map ID of 32 or more returns TID 0 with res_err set. In-range lookups return res_err 0.
- R9: The maps are independent. Programming one map does not change lookups in any other map.
- R10: Reads of word addresses 193 to 255 return 0, and writes to them change nothing that can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_map_id | input | 6 | Map selector; 32 to 63 are out of range |
| lk_dscp | input | 6 | DSCP code point to translate |
| res_valid | output | 1 | Lookup result valid, one cycle after request |
| res_tid | output | 3 | Translated TID |
| res_err | output | 1 | Out-of-range map ID flag |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_addr | input | 8 | Word address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, updated the cycle after cfg_re |

## Verification
A bad stored word shows up on the next read of that address. It also shows up in every lookup whose entry lies in that word. Both appear one cycle after the access. A wrong word index or bit offset in the lookup gives a wrong TID only for particular DSCP values. Entries that cross a word boundary and the last map are where such faults surface. The bench therefore sweeps every DSCP in several maps. It compares each cycle against a bit-level model, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

    localparam int DTM_NUM_MAPS = 32;
    localparam int DTM_NUM_DSCP = 64;
    localparam int DTM_TID_W    = 3;
    localparam int DTM_REG_W    = 32;
    localparam logic [DTM_REG_W-1:0] DTM_RD_MASK = 32'hFFFF_FFFF;

    typedef logic [DTM_TID_W-1:0] tid_t;
    typedef logic [DTM_REG_W-1:0] reg_word_t;

    typedef struct packed {
        logic valid;
        tid_t tid;
        logic err;
    } lk_rsp_t;

    // Words one map occupies when its entries are packed end to end.
    function automatic int words_per_map(input int n_dscp, input int tid_w, input int reg_w);
        return (n_dscp * tid_w + reg_w - 1) / reg_w;
    endfunction

endpackage

// File: rtl/dtm_regstore.sv
module dtm_regstore
    import dtm_pkg::*;
#(
    parameter int NUM_WORDS = 192,
    parameter int ADDR_W    = 8,
    parameter logic [DTM_REG_W-1:0] RD_MASK = DTM_RD_MASK
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_we,
    input  logic                              cfg_re,
    input  logic [ADDR_W-1:0]                 cfg_addr,
    input  reg_word_t                         cfg_wdata,
    output reg_word_t                         cfg_rdata,
    output logic [NUM_WORDS-1:0][DTM_REG_W-1:0] words
);

    localparam int WIDX_W = $clog2(NUM_WORDS);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_WORDS);

    logic [NUM_WORDS-1:0][DTM_REG_W-1:0] words_q;
    logic                                prog_en_q;
    reg_word_t                           rdata_q;
    reg_word_t                           rd_mux;
    logic                                is_map;
    logic                                is_ctrl;
    logic [WIDX_W-1:0]                   widx;

    always_comb begin
        is_map  = cfg_addr < CTRL_ADDR;
        is_ctrl = cfg_addr == CTRL_ADDR;
        widx    = WIDX_W'(cfg_addr);
        if (is_map)
            rd_mux = words_q[widx];
        else if (is_ctrl)
            rd_mux = {{(DTM_REG_W-1){1'b0}}, prog_en_q};
        else
            rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            words_q   <= '0;
            prog_en_q <= 1'b0;
            rdata_q   <= '0;
        end else begin
            if (cfg_re)
                rdata_q <= rd_mux;
            if (cfg_we && is_map && prog_en_q)
                words_q[widx] <= cfg_wdata & RD_MASK;
            if (cfg_we && is_ctrl)
                prog_en_q <= cfg_wdata[0];
        end
    end

    assign words     = words_q;
    assign cfg_rdata = rdata_q;

    AST_MAP_WRITE_MASKED: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && is_map && prog_en_q) |=> (words_q[$past(widx)] == ($past(cfg_wdata) & RD_MASK))) // R2
        else $error("masked map write not stored");

    AST_LOCKED_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        !prog_en_q |=> (words_q == $past(words_q))) // R3
        else $error("map words changed while programming disabled");

    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_re && is_ctrl) |=> (cfg_rdata[DTM_REG_W-1:1] == '0)) // R4
        else $error("control readback upper bits nonzero");

endmodule

// File: rtl/dtm_lookup.sv
module dtm_lookup
    import dtm_pkg::*;
#(
    parameter int NUM_MAPS  = 32,
    parameter int NUM_DSCP  = 64,
    parameter int WPM       = 6,
    parameter int MAP_ID_W  = 6,
    parameter int DSCP_W    = 6
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic                                       lk_valid,
    input  logic [MAP_ID_W-1:0]                        lk_map_id,
    input  logic [DSCP_W-1:0]                          lk_dscp,
    input  logic [NUM_MAPS*WPM-1:0][DTM_REG_W-1:0]     words,
    output lk_rsp_t                                    rsp
);

    localparam int NUM_WORDS = NUM_MAPS * WPM;
    localparam int WIDX_W    = $clog2(NUM_WORDS);
    localparam int OFF_W     = $clog2(DTM_REG_W);

    lk_rsp_t                  rsp_q;
    logic                     in_range;
    int unsigned              bitpos;
    int unsigned              word_in_map;
    int unsigned              lo_sel;
    logic [WIDX_W-1:0]        lo_idx;
    logic [WIDX_W-1:0]        hi_idx;
    logic                     last_word;
    logic [OFF_W-1:0]         off;
    logic [2*DTM_REG_W-1:0]   pair;
    tid_t                     tid_sel;

    always_comb begin
        in_range    = lk_map_id < MAP_ID_W'(NUM_MAPS);
        bitpos      = int'(lk_dscp) * DTM_TID_W;
        word_in_map = bitpos / DTM_REG_W;
        off         = OFF_W'(bitpos % DTM_REG_W);
        lo_sel      = (in_range ? int'(lk_map_id) : 0) * WPM + word_in_map;
        last_word   = word_in_map == (WPM - 1);
        lo_idx      = WIDX_W'(lo_sel);
        hi_idx      = last_word ? lo_idx : WIDX_W'(lo_sel + 1);
        pair        = {(last_word ? {DTM_REG_W{1'b0}} : words[hi_idx]), words[lo_idx]};
        tid_sel     = pair[off +: DTM_TID_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= lk_valid;
            rsp_q.err   <= lk_valid && !in_range;
            rsp_q.tid   <= (lk_valid && in_range) ? tid_sel : '0;
        end
    end

    assign rsp = rsp_q;

    AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_q.valid) // R5
        else $error("lookup response missing");

    AST_RANGE_ERR: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && (lk_map_id >= MAP_ID_W'(NUM_MAPS))) |=> (rsp_q.err && rsp_q.tid == '0)) // R8
        else $error("out-of-range lookup not flagged");

endmodule

// File: rtl/dscp_tid_map.sv
module dscp_tid_map
    import dtm_pkg::*;
#(
    parameter int NUM_MAPS = DTM_NUM_MAPS,
    parameter int NUM_DSCP = DTM_NUM_DSCP,
    parameter logic [DTM_REG_W-1:0] RD_MASK = DTM_RD_MASK,
    localparam int WPM       = words_per_map(NUM_DSCP, DTM_TID_W, DTM_REG_W),
    localparam int NUM_WORDS = NUM_MAPS * WPM,
    localparam int MAP_ID_W  = $clog2(NUM_MAPS) + 1,
    localparam int DSCP_W    = $clog2(NUM_DSCP),
    localparam int ADDR_W    = $clog2(NUM_WORDS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lk_valid,
    input  logic [MAP_ID_W-1:0]  lk_map_id,
    input  logic [DSCP_W-1:0]    lk_dscp,
    output logic                 res_valid,
    output logic [DTM_TID_W-1:0] res_tid,
    output logic                 res_err,
    input  logic                 cfg_we,
    input  logic                 cfg_re,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DTM_REG_W-1:0] cfg_wdata,
    output logic [DTM_REG_W-1:0] cfg_rdata
);

    logic [NUM_WORDS-1:0][DTM_REG_W-1:0] words;
    lk_rsp_t                             rsp;

    dtm_regstore #(
        .NUM_WORDS (NUM_WORDS),
        .ADDR_W    (ADDR_W),
        .RD_MASK   (RD_MASK)
    ) i_store (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_re    (cfg_re),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .words     (words)
    );

    dtm_lookup #(
        .NUM_MAPS (NUM_MAPS),
        .NUM_DSCP (NUM_DSCP),
        .WPM      (WPM),
        .MAP_ID_W (MAP_ID_W),
        .DSCP_W   (DSCP_W)
    ) i_lookup (
        .clk       (clk),
        .rst       (rst),
        .lk_valid  (lk_valid),
        .lk_map_id (lk_map_id),
        .lk_dscp   (lk_dscp),
        .words     (words),
        .rsp       (rsp)
    );

    assign res_valid = rsp.valid;
    assign res_tid   = rsp.tid;
    assign res_err   = rsp.err;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (res_tid == '0 && !res_err)) // R5
        else $error("result fields active without valid");

    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid) // R5
        else $error("spurious response valid");

endmodule

// File: tb/test_dscp_tid_map.sv
module test_dscp_tid_map;

    localparam int CLK_PERIOD = 10;
    localparam int NMAPS = 32;
    localparam int NDSCP = 64;
    localparam int NW    = 192;
    localparam int CTRL  = 192;
    localparam logic [31:0] MASK = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [5:0]  lk_map_id = '0;
    logic [5:0]  lk_dscp = '0;
    logic        res_valid;
    logic [2:0]  res_tid;
    logic        res_err;
    logic        cfg_we = 1'b0;
    logic        cfg_re = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    dscp_tid_map i_dscp_tid_map (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_map_id(lk_map_id), .lk_dscp(lk_dscp),
        .res_valid(res_valid), .res_tid(res_tid), .res_err(res_err),
        .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_req = "R1";

    // intended TID table and bit-level register model
    int          tidtab [NMAPS][NDSCP];
    logic [31:0] m_words [NW];
    logic        m_en;
    logic        e_valid, e_err;
    logic [2:0]  e_tid;
    logic [31:0] e_rdata;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [2:0] model_tid(input int m, input int d);
        logic [2:0] t;
        for (int b = 0; b < 3; b++) begin
            int bit_abs = m * NW / NMAPS * 32 + d * 3 + b;
            t[b] = m_words[bit_abs / 32][bit_abs % 32];
        end
        return t;
    endfunction

    function automatic logic [31:0] packed_word(input int m, input int w);
        logic [31:0] v = '0;
        for (int d = 0; d < NDSCP; d++)
            for (int b = 0; b < 3; b++) begin
                int pos = d * 3 + b;
                if (pos / 32 == w) v[pos % 32] = tidtab[m][d][b];
            end
        return v;
    endfunction

    // cycle reference model
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NW; i++) m_words[i] = '0;
            m_en = 0; e_valid = 0; e_err = 0; e_tid = 0; e_rdata = 0;
        end else begin
            e_valid = lk_valid;
            e_err   = lk_valid && (lk_map_id >= NMAPS);
            e_tid   = (lk_valid && lk_map_id < NMAPS) ? model_tid(int'(lk_map_id), int'(lk_dscp)) : 3'd0;
            if (cfg_re)
                e_rdata = (cfg_addr < NW) ? m_words[cfg_addr] : (cfg_addr == CTRL) ? {31'd0, m_en} : 32'd0;
            if (cfg_we) begin
                if (cfg_addr < NW && m_en) m_words[cfg_addr] = cfg_wdata & MASK;
                else if (cfg_addr == CTRL) m_en = cfg_wdata[0];
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(res_valid == e_valid, cur_req, "cycle res_valid", int'(res_valid), int'(e_valid));
            chk(res_tid == e_tid, cur_req, "cycle res_tid", int'(res_tid), int'(e_tid));
            chk(res_err == e_err, cur_req, "cycle res_err", int'(res_err), int'(e_err));
            chk(cfg_rdata == e_rdata, cur_req, "cycle cfg_rdata", int'(cfg_rdata), int'(e_rdata));
        end
    end

    task automatic cfg_wr(input int a, input logic [31:0] d);
        cfg_we = 1; cfg_addr = 8'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic cfg_rd(input int a, input logic [31:0] exp, input string tag);
        cfg_re = 1; cfg_addr = 8'(a);
        @(negedge clk);
        cfg_re = 0;
        chk(cfg_rdata == exp, tag, $sformatf("read addr %0d", a), int'(cfg_rdata), int'(exp));
    endtask

    task automatic look(input int m, input int d, input int exp_tid, input bit exp_err, input string tag);
        lk_valid = 1; lk_map_id = 6'(m); lk_dscp = 6'(d);
        @(negedge clk);
        lk_valid = 0;
        chk(res_valid && res_tid == 3'(exp_tid) && res_err == exp_err, tag,
            $sformatf("lookup map %0d dscp %0d tid", m, d), int'(res_tid), exp_tid);
    endtask

    task automatic program_map(input int m);
        for (int w = 0; w < 6; w++) cfg_wr(m * 6 + w, packed_word(m, w));
    endtask

    initial begin
        for (int m = 0; m < NMAPS; m++)
            for (int d = 0; d < NDSCP; d++) tidtab[m][d] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        cur_req = "R1";
        cfg_rd(0, 0, "R1");
        cfg_rd(191, 0, "R1");
        cfg_rd(CTRL, 0, "R1");
        look(0, 0, 0, 0, "R1");
        look(31, 63, 0, 0, "R1");

        cur_req = "R3";
        cfg_wr(6, 32'hDEAD_BEEF);
        cfg_rd(6, 0, "R3");

        cur_req = "R4";
        cfg_wr(CTRL, 32'hFFFF_FFFF);
        cfg_rd(CTRL, 32'd1, "R4");

        cur_req = "R2";
        for (int d = 0; d < NDSCP; d++) begin
            tidtab[0][d]  = (d ^ 3) & 7;
            tidtab[1][d]  = (d * 5 + 1) & 7;
            tidtab[31][d] = (63 - d) & 7;
        end
        program_map(0);
        program_map(1);
        program_map(31);
        for (int w = 0; w < 6; w++) cfg_rd(6 + w, packed_word(1, w), "R2");
        cfg_rd(186, packed_word(31, 0), "R2");

        cur_req = "R3";
        cfg_wr(CTRL, 0);
        cfg_rd(CTRL, 0, "R4");
        cfg_wr(6, 32'h0);
        cfg_wr(7, 32'h0);
        cfg_rd(6, packed_word(1, 0), "R3");
        look(1, 10, tidtab[1][10], 0, "R3");

        cur_req = "R6";
        for (int d = 0; d < NDSCP; d++) begin
            bit strad = (d == 10 || d == 21 || d == 42 || d == 53);
            look(0, d, tidtab[0][d], 0, strad ? "R7" : "R6");
            look(1, d, tidtab[1][d], 0, strad ? "R7" : "R6");
            look(31, d, tidtab[31][d], 0, strad ? "R7" : "R6");
        end

        cur_req = "R5";
        for (int d = 0; d < 16; d++) begin
            lk_valid = 1; lk_map_id = 6'(1); lk_dscp = 6'(d * 4);
            @(negedge clk);
        end
        lk_valid = 0;
        @(negedge clk);
        chk(!res_valid && res_tid == 0 && !res_err, "R5", "idle response", int'(res_valid), 0);

        cur_req = "R9";
        look(2, 10, 0, 0, "R9");
        look(30, 63, 0, 0, "R9");

        cur_req = "R8";
        look(32, 5, 0, 1, "R8");
        look(63, 63, 0, 1, "R8");

        cur_req = "R10";
        cfg_wr(200, 32'h1234_5678);
        cfg_rd(200, 0, "R10");
        cfg_rd(255, 0, "R10");

        cur_req = "R7";
        cfg_wr(CTRL, 1);
        tidtab[1][10] = 6;
        tidtab[1][21] = 5;
        program_map(1);
        cfg_wr(CTRL, 0);
        look(1, 10, 6, 0, "R7");
        look(1, 21, 5, 0, "R7");
        look(1, 9, tidtab[1][9], 0, "R7");
        look(1, 11, tidtab[1][11], 0, "R7");
        look(0, 10, tidtab[0][10], 0, "R9");

        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule